// File: doc/BRIEF.md
# SMBus Register Slave with Pointer

This block is the serial front end of a management chip. It watches the SMBus clock and data lines, recognises its own 7-bit device address and gives the host byte-wide access to a register file that sits outside the block. Every write starts by loading an 8-bit pointer. A byte that follows the pointer goes to the register the pointer selects, and reads always return the register at the current pointer. The block therefore supports send byte, write byte, receive byte and read byte, including a repeated start between the pointer write and the read.

The device address comes from a pin with three states, which is decoded once, at the first START after reset. A stuck-low clock line returns the slave to idle after a programmable number of system clocks, unless the disable input is high. An optional packet error code byte (CRC-8) is checked on writes and supplied on reads when the master clocks it. When an external alert is pending, the slave also answers the alert response address with its own address.

Top module: `smb_reg_slave`

## Requirements
- R1: The address pin code sets the device address: 2'b00 gives 0x2C, 2'b01 gives 0x2E, 2'b10 gives 0x2F, and 2'b11 also gives 0x2E. The slave acknowledges a matching address byte by holding SDA low through the 9th clock and releases SDA for any other address. It changes its SDA drive only while the filtered SCL is low. After reset, sda_pd_o, reg_wr_o and reg_rd_o are low.
- R2: The pin code is captured at the first START after reset. Later changes on the pin have no effect until the next reset.
- R3: In a write, the first data byte loads the pointer. The second data byte produces a one-cycle reg_wr_o pulse with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. Both bytes are acknowledged.
- R4: A write with a single data byte (send byte) changes only the pointer and gives no reg_wr_o pulse. A later receive byte returns the register at that pointer.
- R5: A read raises reg_rd_o for one cycle with reg_addr_o equal to the pointer. reg_rdata_i is captured in that cycle and shifted out MSB first.
- R6: A repeated START after the pointer byte starts a read without an intermediate STOP. The read returns the register that was just selected.
- R7: If SCL stays low for TO_CYCLES system clocks, the slave goes idle and releases SDA. While to_dis_i is high this release does not happen. It takes place as soon as to_dis_i drops, provided SCL is still low.
- R8: The PEC is a CRC-8 with polynomial 0x07 and initial value 0. It covers every byte since the first START, including the address byte sent after a repeated START. A third write data byte is acknowledged only if it equals the PEC; the register write has already taken place. In a read, the byte sent after a master ACK of the data byte is the PEC.
- R9: With alert_i high, the address byte 0x19 (address 0x0C, read) is acknowledged and answered with {device address, 1'b0}. With alert_i low, the same byte is not acknowledged.
- R10: SCL and SDA pass a two-flop synchroniser and a filter that ignores pulses shorter than FILT_LEN clocks. A 2-cycle SCL glitch inside a bit does not shift a bit. START and STOP are SDA edges while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pd_o | output | 1 | High pulls SDA low (open-drain) |
| addr_pin_i | input | 2 | Address pin state: 00 low, 01 floating, 10 high |
| alert_i | input | 1 | Alert pending; enables the alert response answer |
| to_dis_i | input | 1 | High disables the stuck-clock timeout |
| reg_addr_o | output | 8 | Register address (current pointer) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, captured while reg_rd_o is high |

## Verification
A wrong pointer shows up in the same transaction as a reg_wr_o pulse at the wrong reg_addr_o. If it survives until the next read, it also shows as a wrong byte on SDA. A slip in the bit counter or the acknowledge state appears within nine SCL periods as a missing or misplaced ACK. An error in the CRC bookkeeping appears as a NACK of a correct PEC byte or as a wrong PEC byte in a read. A wrong latch or timeout state shows up as a wrong ACK to the next address byte, or as SDA still held low once the timeout window has passed.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'h0C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } smb_state_e;

  // Map the three-state pin code onto the low address bits.
  function automatic logic [6:0] addr_from_pin(input logic [1:0] pin, input logic [6:0] base);
    case (pin)
      2'b00:   return base;
      2'b10:   return base | 7'h03;
      default: return base | 7'h02;
    endcase
  endfunction

  // CRC-8, polynomial x^8+x^2+x+1, one byte folded in MSB first.
  function automatic logic [7:0] crc8_update(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc ^ din;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != filt_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          filt_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R10: the output only moves towards a level the synchroniser presented
  a_r10_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_o) |-> ($past(sync_q[1]) == filt_o));

endmodule

// File: rtl/smb_bus_timeout.sv
module smb_bus_timeout #(
  parameter int TO_CYCLES = 28000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_low_i,
  input  logic dis_i,
  output logic hit_o
);
  localparam int CW = $clog2(TO_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (!scl_low_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(TO_CYCLES))    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = !dis_i && (cnt_q == CW'(TO_CYCLES));

  // R7: a timeout only follows a cycle in which SCL was low
  a_r7_hit_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(scl_low_i));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h2C,
  parameter int         FILT_LEN  = 3,
  parameter int         TO_CYCLES = 28000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic [1:0] addr_pin_i,
  input  logic       alert_i,
  input  logic       to_dis_i,
  output logic [7:0] reg_addr_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_rd_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int NLINES = 2;

  // ---------------- line conditioning ----------------
  logic [NLINES-1:0] raw_w, filt_w;
  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_w[g]),
      .filt_o(filt_w[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // named bus events
  logic ev_scl_rise, ev_scl_fall, ev_start, ev_stop, to_hit;
  assign ev_scl_rise = scl_f & ~scl_q;
  assign ev_scl_fall = ~scl_f & scl_q;
  assign ev_start    = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop     = scl_f & scl_q & ~sda_q & sda_f;

  smb_bus_timeout #(.TO_CYCLES(TO_CYCLES)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_low_i(~scl_f),
    .dis_i    (to_dis_i),
    .hit_o    (to_hit)
  );

  // ---------------- protocol state ----------------
  smb_state_e  state_q;
  logic [2:0]  bitcnt_q;
  logic [7:0]  shreg_q;
  logic        rx_done_q, addr_phase_q, is_read_q, is_ara_q;
  logic [1:0]  byte_idx_q, tx_cnt_q;
  logic [6:0]  dev_addr_q;
  logic        addr_lat_q;
  logic [7:0]  ptr_q, crc_q, wdata_q;
  logic        sda_pd_q, reg_wr_q;

  // byte evaluation
  logic addr_hit, ara_hit, rx_eval, rx_ack;
  assign addr_hit = (shreg_q[7:1] == dev_addr_q);
  assign ara_hit  = (shreg_q[7:1] == ALERT_RESP_ADDR) && shreg_q[0] && alert_i;
  assign rx_eval  = (state_q == ST_RX) && rx_done_q && ev_scl_fall && !to_hit;
  assign rx_ack   = addr_phase_q ? (addr_hit || ara_hit)
                  : ((byte_idx_q == 2'd0) || (byte_idx_q == 2'd1) ||
                     ((byte_idx_q == 2'd2) && (shreg_q == crc_q)));

  // transmit load
  logic       ld_tx, ld_first;
  logic [7:0] tx_byte;
  assign ld_first = (state_q == ST_RX_ACK) && is_read_q && ev_scl_fall && !to_hit;
  assign ld_tx    = ld_first || ((state_q == ST_TX_ACK) && ev_scl_fall && !to_hit);
  assign tx_byte  = (state_q == ST_RX_ACK) ? (is_ara_q ? {dev_addr_q, 1'b0} : reg_rdata_i)
                  : ((tx_cnt_q == 2'd1) ? crc_q : 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      bitcnt_q     <= '0;
      shreg_q      <= '0;
      rx_done_q    <= 1'b0;
      addr_phase_q <= 1'b0;
      is_read_q    <= 1'b0;
      is_ara_q     <= 1'b0;
      byte_idx_q   <= '0;
      tx_cnt_q     <= '0;
      dev_addr_q   <= BASE_ADDR;
      addr_lat_q   <= 1'b0;
      ptr_q        <= '0;
      crc_q        <= '0;
      wdata_q      <= '0;
      sda_pd_q     <= 1'b0;
      reg_wr_q     <= 1'b0;
    end else begin
      reg_wr_q <= 1'b0;
      if (to_hit) begin
        state_q   <= ST_IDLE;
        sda_pd_q  <= 1'b0;
        rx_done_q <= 1'b0;
        crc_q     <= '0;
      end else if (ev_start) begin
        state_q      <= ST_RX;
        bitcnt_q     <= '0;
        rx_done_q    <= 1'b0;
        addr_phase_q <= 1'b1;
        sda_pd_q     <= 1'b0;
        if (state_q == ST_IDLE) crc_q <= '0;
        if (!addr_lat_q) begin
          dev_addr_q <= addr_from_pin(addr_pin_i, BASE_ADDR);
          addr_lat_q <= 1'b1;
        end
      end else if (ev_stop) begin
        state_q   <= ST_IDLE;
        sda_pd_q  <= 1'b0;
        rx_done_q <= 1'b0;
        crc_q     <= '0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (ev_scl_rise && !rx_done_q) begin
              shreg_q  <= {shreg_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 3'd1;
              if (bitcnt_q == 3'd7) rx_done_q <= 1'b1;
            end else if (rx_eval) begin
              rx_done_q <= 1'b0;
              bitcnt_q  <= '0;
              crc_q     <= crc8_update(crc_q, shreg_q);
              if (rx_ack) begin
                sda_pd_q <= 1'b1;
                state_q  <= ST_RX_ACK;
              end else begin
                state_q  <= ST_WAIT;
              end
              if (addr_phase_q) begin
                addr_phase_q <= 1'b0;
                is_read_q    <= shreg_q[0];
                is_ara_q     <= !addr_hit;
                byte_idx_q   <= '0;
              end else begin
                if (byte_idx_q == 2'd0) ptr_q <= shreg_q;
                if (byte_idx_q == 2'd1) begin
                  reg_wr_q <= 1'b1;
                  wdata_q  <= shreg_q;
                end
                if (byte_idx_q != 2'd3) byte_idx_q <= byte_idx_q + 2'd1;
              end
            end
          end
          ST_RX_ACK, ST_TX_ACK: begin
            if (ld_tx) begin
              shreg_q  <= tx_byte;
              sda_pd_q <= ~tx_byte[7];
              bitcnt_q <= '0;
              state_q  <= ST_TX;
              crc_q    <= crc8_update(crc_q, tx_byte);
              tx_cnt_q <= ld_first ? 2'd1 : 2'd2;
            end else if (state_q == ST_RX_ACK && ev_scl_fall) begin
              sda_pd_q <= 1'b0;
              state_q  <= ST_RX;
            end else if (state_q == ST_TX_ACK && ev_scl_rise && sda_f) begin
              state_q  <= ST_WAIT;
            end
          end
          ST_TX: begin
            if (ev_scl_fall) begin
              if (bitcnt_q == 3'd7) begin
                sda_pd_q <= 1'b0;
                state_q  <= ST_TX_ACK;
                bitcnt_q <= '0;
              end else begin
                shreg_q  <= {shreg_q[6:0], 1'b0};
                sda_pd_q <= ~shreg_q[6];
                bitcnt_q <= bitcnt_q + 3'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o    = sda_pd_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wr_o    = reg_wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = ld_first && !is_ara_q;

  // ---------------- assertions ----------------
  a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_q) |-> !scl_f);

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    addr_lat_q |=> (addr_lat_q && $stable(dev_addr_q)));

  a_r3_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  a_r5_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (!reg_rd_o && state_q == ST_TX));

  a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));

  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (state_q == ST_IDLE && !sda_pd_q));

endmodule

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 12;
  localparam int TO_CYC     = 300;

  // table of {pointer, data}
  localparam logic [15:0] VEC [6] = '{16'h035A, 16'h103C, 16'h7FA5,
                                      16'hC300, 16'h44FF, 16'h0281};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_pin = 2'b10;
  logic alert = 1'b0, to_dis = 1'b0;
  logic sda_pd, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [256];
  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0;
  logic [7:0] last_wr_addr = 8'h00, last_wr_data = 8'h00, last_rd_addr = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_pd;
  assign reg_rdata = mem[reg_addr];

  smb_reg_slave #(.TO_CYCLES(TO_CYC)) u_smb_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd),
    .addr_pin_i(addr_pin), .alert_i(alert), .to_dis_i(to_dis),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt        <= wr_cnt + 1;
      last_wr_addr  <= reg_addr;
      last_wr_data  <= reg_wdata;
    end
    if (reg_rd) last_rd_addr <= reg_addr;
  end

  function automatic logic [7:0] crc_ref(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c = crc;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[7] ^ b[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_rstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic clk_bit(input logic v, input bit glitch, output logic seen);
    sda_m = v; tick(Q); scl_m = 1;
    if (glitch) begin
      tick(6); scl_m = 0; tick(2); scl_m = 1; tick(Q - 8);
    end else begin
      tick(Q);
    end
    seen = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch && (i == 4), s);
    clk_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic m_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(!m_ack, 1'b0, s);
  endtask

  logic [6:0] my_addr = 7'h2F;

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, input string tag);
    logic a0, a1, a2;
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1);
    send_byte(d, 0, a2); bus_stop();
    check(tag, {a0, a1, a2}, 3'b111);
  endtask

  task automatic read_rs(input logic [7:0] p, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1);
    bus_rstart(); send_byte({my_addr, 1'b1}, 0, a2); recv_byte(d, 1'b0); bus_stop();
    check("R6 acks around repeated start", {a0, a1, a2}, 3'b111);
  endtask

  task automatic read_sb(input logic [7:0] p, output logic [7:0] d);
    logic a0, a1, a2;
    int wc;
    wc = wr_cnt;
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1); bus_stop();
    check("R4 send byte gives no write strobe", wr_cnt, wc);
    bus_start(); send_byte({my_addr, 1'b1}, 0, a2); recv_byte(d, 1'b0); bus_stop();
    check("R4 acks of send/receive byte", {a0, a1, a2}, 3'b111);
  endtask

  task automatic do_reset();
    rst_n = 0; tick(5); rst_n = 1; tick(5);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, p, crc, pec;
    logic a0, a1, a2, a3;
    tick(5);
    // R1 reset state
    check("R1 reset sda_pd_o", sda_pd, 1'b0);
    check("R3 reset reg_wr_o", reg_wr, 1'b0);
    check("R5 reset reg_rd_o", reg_rd, 1'b0);
    rst_n = 1; tick(5);

    // table walk: writes (R3)
    for (int i = 0; i < 6; i++) begin
      int wc;
      wc = wr_cnt;
      write_reg(VEC[i][15:8], VEC[i][7:0], "R3 write byte acks");
      check("R3 one write strobe", wr_cnt, wc + 1);
      check("R3 write address", last_wr_addr, VEC[i][15:8]);
      check("R3 write data", last_wr_data, VEC[i][7:0]);
    end
    // table walk: reads (R4 odd, R6 even, R5 all)
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 0) read_rs(VEC[i][15:8], d);
      else            read_sb(VEC[i][15:8], d);
      check("R5 read data MSB first", d, VEC[i][7:0]);
      check("R5 read strobe address", last_rd_addr, VEC[i][15:8]);
    end

    // R2: pin change after latch has no effect
    addr_pin = 2'b00;
    bus_start(); send_byte({7'h2C, 1'b0}, 0, a0); bus_stop();
    check("R2 new pin address ignored", a0, 1'b0);
    bus_start(); send_byte({7'h2F, 1'b0}, 0, a0); bus_stop();
    check("R2 latched address still acked", a0, 1'b1);

    // R9: alert response address
    alert = 1;
    bus_start(); send_byte(8'h19, 0, a0); recv_byte(d, 1'b0); bus_stop();
    check("R9 ARA acked", a0, 1'b1);
    check("R9 ARA returns own address", d, {7'h2F, 1'b0});
    alert = 0;
    bus_start(); send_byte(8'h19, 0, a0); bus_stop();
    check("R9 ARA ignored without alert", a0, 1'b0);

    // R8: PEC on write, good and bad
    p = 8'h21; d = 8'h6E;
    crc = crc_ref(crc_ref(crc_ref(8'h00, {my_addr, 1'b0}), p), d);
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1);
    send_byte(d, 0, a2); send_byte(crc, 0, a3); bus_stop();
    check("R8 good PEC acked", {a0, a1, a2, a3}, 4'b1111);
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1);
    send_byte(d, 0, a2); send_byte(crc ^ 8'h01, 0, a3); bus_stop();
    check("R8 bad PEC not acked", {a0, a1, a2, a3}, 4'b1110);
    // R8: PEC on read
    bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(p, 0, a1);
    bus_rstart(); send_byte({my_addr, 1'b1}, 0, a2);
    recv_byte(d, 1'b1); recv_byte(pec, 1'b0); bus_stop();
    crc = crc_ref(crc_ref(crc_ref(crc_ref(8'h00, {my_addr, 1'b0}), p), {my_addr, 1'b1}), d);
    check("R8 read data before PEC", d, 8'h6E);
    check("R8 read PEC value", pec, crc);

    // R10: SCL glitch inside an address bit
    bus_start(); send_byte({my_addr, 1'b0}, 1, a0); send_byte(8'h55, 0, a1);
    send_byte(8'h99, 0, a2); bus_stop();
    check("R10 glitched transfer acked", {a0, a1, a2}, 3'b111);
    check("R10 glitched transfer data", last_wr_data, 8'h99);

    // R7: timeout enabled, then disabled
    for (int k = 0; k < 2; k++) begin
      to_dis = (k == 1);
      bus_start(); send_byte({my_addr, 1'b0}, 0, a0); send_byte(8'h10, 0, a1); bus_stop();
      bus_start(); send_byte({my_addr, 1'b1}, 0, a0);
      check("R5 slave drives first data bit", sda_pd, 1'b1);
      tick(TO_CYC + 10);
      if (k == 1) begin
        check("R7 no release while disabled", sda_pd, 1'b1);
        to_dis = 0; tick(5);
      end
      check("R7 SDA released after timeout", sda_pd, 1'b0);
      bus_stop();
    end
    read_sb(8'h10, d);
    check("R7 operation after timeout", d, 8'h3C);

    // R1: pin decode for every code
    for (int c = 0; c < 4; c++) begin
      logic [6:0] exp_a;
      exp_a = (c == 0) ? 7'h2C : (c == 2) ? 7'h2F : 7'h2E;
      addr_pin = 2'(c);
      do_reset();
      bus_start(); send_byte({exp_a, 1'b0}, 0, a0); bus_stop();
      check("R1 decoded address acked", a0, 1'b1);
      bus_start(); send_byte({exp_a ^ 7'h01, 1'b0}, 0, a1); bus_stop();
      check("R1 other address not acked", a1, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule